// File: doc/BRIEF.md
# Command-Decoded Single-Port RAM

This block is a small synchronous memory that is driven entirely through one command word. Each command carries a two-bit opcode above a data payload. With the opcode the user either sets one of two held pointers (one for writing, one for reading), stores the payload at the write pointer, or fetches the word at the read pointer. There is no separate address bus: both addresses reach the memory as payloads on the same input as the data.

A producer presents a command together with a one-cycle valid strobe. The block never stalls, so it has no ready output and applies no back-pressure: every command whose strobe is high at a rising clock edge is taken at that edge. On the result side the block asserts its output valid strobe for exactly one cycle per read command, and the consumer must take `dout` in that cycle. If the consumer cannot, it has to hold back its read commands. Read data is registered, and `dout` keeps its last value between reads.

Depth, address width and data width are parameters. The default is 256 words of 8 bits with an 8-bit address. The memory contents are not cleared by reset.

Top module: `cmd_ram`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `tx_valid` is 0. Reset also sets both the write pointer and the read pointer to address 0. After reset, a write issued without first loading an address goes to word 0, and a read issued without first loading an address returns word 0.
- R2: A rising edge at which `rx_valid` is low has no effect, whatever value `din` holds. Memory, both pointers and `dout` stay unchanged, and `tx_valid` is low after that edge.
- R3: A command with `din[9:8]` = 2'b00 loads `din[7:0]` into the write pointer.
- R4: A command with `din[9:8]` = 2'b01 stores `din[7:0]` at the word named by the write pointer. The pointer is not changed, so a second write replaces the first one.
- R5: A command with `din[9:8]` = 2'b10 loads `din[7:0]` into the read pointer.
- R6: A command with `din[9:8]` = 2'b11 places the word at the read pointer on `dout` and raises `tx_valid`, both at the edge that accepts the command and held for one cycle. The payload bits `din[7:0]` of this command are ignored. Reads issued back to back produce back-to-back valid results.
- R7: `tx_valid` is low after every edge that does not accept a command with opcode 2'b11.
- R8: `dout` changes only at an edge that also raises `tx_valid`. In every other cycle it holds the last value read.
- R9: The two pointers are independent. Loading one of them leaves the other unchanged.
- R10: A read accepted on the edge right after a write to the same word returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DATA_W+2 (10) | Command word: opcode in the top two bits, payload below |
| rx_valid | input | 1 | Command strobe; `din` is taken at a rising edge where this is high |
| dout | output | DATA_W (8) | Registered read data |
| tx_valid | output | 1 | One-cycle strobe marking a fresh read result on `dout` |

## Verification
Pointer loads and writes have no direct output. They become visible one cycle later, through the read that follows them. A read result (`dout` together with `tx_valid`) is due exactly one rising edge after the falling edge at which the bench presents the read command. The bench drives every command on a falling edge and samples the outputs on the next falling edge. It predicts in that same cycle whether `tx_valid` must be high, and it compares `dout` against a queued value from its own model of memory and pointers. In every cycle without a result, the bench checks that `tx_valid` is low and that `dout` has not moved.

// File: rtl/cmd_ram_pkg.sv
package cmd_ram_pkg;

  typedef enum logic [1:0] {
    OP_SET_WPTR = 2'b00,
    OP_STORE    = 2'b01,
    OP_SET_RPTR = 2'b10,
    OP_FETCH    = 2'b11
  } cmd_op_e;

endpackage

// File: rtl/cmdram_decode.sv
module cmdram_decode
  import cmd_ram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cmd_valid,
  input  logic [DATA_W+1:0] cmd,
  output logic              ld_wptr,
  output logic              store,
  output logic              ld_rptr,
  output logic              fetch,
  output logic [DATA_W-1:0] payload
);

  cmd_op_e op;

  always_comb begin
    op      = cmd_op_e'(cmd[DATA_W+1:DATA_W]);
    payload = cmd[DATA_W-1:0];
    ld_wptr = 1'b0;
    store   = 1'b0;
    ld_rptr = 1'b0;
    fetch   = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_SET_WPTR: ld_wptr = 1'b1;
        OP_STORE:    store   = 1'b1;
        OP_SET_RPTR: ld_rptr = 1'b1;
        OP_FETCH:    fetch   = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cmdram_ptrs.sv
module cmdram_ptrs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_wptr,
  input  logic              ld_rptr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (ld_wptr) wptr <= addr_in;
      if (ld_rptr) rptr <= addr_in;
    end
  end

endmodule

// File: rtl/cmdram_store.sv
module cmdram_store #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rptr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] cells [DEPTH];

  // array itself carries no reset
  always_ff @(posedge clk) begin
    if (wr_en) cells[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= cells[rptr];
    end
  end

endmodule

// File: rtl/cmd_ram.sv
module cmd_ram #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int CMD_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  din,
  input  logic              rx_valid,
  output logic [DATA_W-1:0] dout,
  output logic              tx_valid
);

  logic              ld_wptr, store, ld_rptr, fetch;
  logic [DATA_W-1:0] payload;
  logic [ADDR_W-1:0] addr_in, wptr, rptr;

  cmdram_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_valid (rx_valid),
    .cmd       (din),
    .ld_wptr   (ld_wptr),
    .store     (store),
    .ld_rptr   (ld_rptr),
    .fetch     (fetch),
    .payload   (payload)
  );

  generate
    if (ADDR_W <= DATA_W) begin : g_addr_slice
      assign addr_in = payload[ADDR_W-1:0];
    end else begin : g_addr_pad
      assign addr_in = {{(ADDR_W-DATA_W){1'b0}}, payload};
    end
  endgenerate

  cmdram_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_wptr (ld_wptr),
    .ld_rptr (ld_rptr),
    .addr_in (addr_in),
    .wptr    (wptr),
    .rptr    (rptr)
  );

  cmdram_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (store),
    .wptr   (wptr),
    .wdata  (payload),
    .rd_en  (fetch),
    .rptr   (rptr),
    .rdata  (dout),
    .rvalid (tx_valid)
  );

endmodule

// File: rtl/cmd_ram_chk.sv
module cmd_ram_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W+1:0] din,
  input logic              rx_valid,
  input logic [DATA_W-1:0] dout,
  input logic              tx_valid
);

  logic is_fetch;
  assign is_fetch = rx_valid && (din[DATA_W+1:DATA_W] == 2'b11);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (dout == '0 && !tx_valid); // R1
    end
  end

  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!tx_valid && $stable(dout))); // R2

  AST_FETCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> tx_valid); // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !is_fetch |=> !tx_valid); // R7

  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> $stable(dout)); // R8

endmodule

bind cmd_ram cmd_ram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .din      (din),
  .rx_valid (rx_valid),
  .dout     (dout),
  .tx_valid (tx_valid)
);

// File: tb/sim_cmd_ram.sv
module sim_cmd_ram;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] dout;
  logic       tx_valid;

  cmd_ram u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .rx_valid (rx_valid),
    .dout     (dout),
    .tx_valid (tx_valid)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [256];
  logic [7:0] m_wp = '0;
  logic [7:0] m_rp = '0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] last_dout = '0;
  logic       acc_fetch = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] pl, input string tag);
    @(negedge clk);
    din = {op, pl};
    rx_valid = 1'b1;
    case (op)
      2'b00: m_wp = pl;
      2'b01: m_mem[m_wp] = pl;
      2'b10: m_rp = pl;
      default: begin
        exp_q.push_back(m_mem[m_rp]);
        tag_q.push_back(tag);
      end
    endcase
  endtask

  task automatic idle(input logic [9:0] junk);
    @(negedge clk);
    din = junk;
    rx_valid = 1'b0;
  endtask

  // input-side observation: was a fetch taken at this edge
  always @(posedge clk) acc_fetch <= rst_n && rx_valid && (din[9:8] == 2'b11);

  // monitor: results due one edge after the command
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tx_valid == acc_fetch, acc_fetch ? "R6 tx_valid" : "R7 tx_valid",
            tx_valid, acc_fetch);
      if (tx_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", dout, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dout == e, t, dout, e);
          last_dout = dout;
        end
      end else begin
        check(dout == last_dout, "R8 dout hold", dout, last_dout);
      end
    end
  end

  initial begin
    #(20 * 5000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(dout == 8'h00 && tx_valid == 1'b0, "R1 reset outputs", {tx_valid, dout}, 0);
    rst_n = 1'b1;

    // R1: pointers start at word 0
    cmd(2'b01, 8'h5A, "R1");
    cmd(2'b11, 8'hC3, "R1");
    // R2: strobe low, commands ignored
    idle({2'b01, 8'hFF});
    idle({2'b00, 8'h10});
    idle({2'b11, 8'h00});
    cmd(2'b11, 8'h00, "R2");
    // R3 / R4: load write pointer, overwrite
    cmd(2'b00, 8'h10, "R3");
    cmd(2'b01, 8'h11, "R4");
    cmd(2'b01, 8'h22, "R4");
    cmd(2'b00, 8'hFF, "R3");
    cmd(2'b01, 8'h99, "R3");
    // R5
    cmd(2'b10, 8'h10, "R5");
    cmd(2'b11, 8'h00, "R4");
    cmd(2'b10, 8'hFF, "R5");
    cmd(2'b11, 8'h3C, "R5");
    // R9: write pointer load leaves read pointer
    cmd(2'b00, 8'h30, "R9");
    cmd(2'b11, 8'h00, "R9");
    cmd(2'b01, 8'h77, "R9");
    cmd(2'b11, 8'h00, "R9");
    cmd(2'b10, 8'h30, "R9");
    cmd(2'b11, 8'h00, "R9");
    // R10: write then read at once, then back-to-back reads
    cmd(2'b00, 8'h40, "R10");
    cmd(2'b10, 8'h40, "R10");
    cmd(2'b01, 8'hAB, "R10");
    cmd(2'b11, 8'h00, "R10");
    cmd(2'b11, 8'hFF, "R6");
    cmd(2'b11, 8'h55, "R6");
    idle('0);
    // sweep
    for (int i = 0; i < 16; i++) begin
      cmd(2'b00, 8'(i * 13 + 1), "R4");
      cmd(2'b01, 8'(i * 7 + 3), "R4");
    end
    for (int i = 0; i < 16; i++) begin
      cmd(2'b10, 8'(i * 13 + 1), "R5");
      cmd(2'b11, 8'h00, "R6");
      idle({2'b01, 8'hEE});
    end
    idle('0);
    idle('0);
    @(negedge clk);
    check(exp_q.size() == 0, "R6 results outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule